// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. Two component predictors run side by side. The first is a two-level local predictor: a per-branch history selects a saturating counter. The second is a global predictor: the branch address, XOR-ed with a shared history of recent outcomes, selects a counter. A third table of saturating counters, indexed by branch address, acts as the chooser and decides which of the two answers is used.

The predict side is combinational. A front end presents a branch address and reads the taken/not-taken guess in the same cycle. The update side is a one-cycle write port that takes the resolved branch address and its real outcome. The block recomputes both component predictions from the current table contents, trains all three tables, and shifts both the branch's local history and the global history. All table sizes and counter widths are parameters.

Top module: `tourney_pred`

## Requirements
- R1: The prediction is a combinational function of `pred_pc_i` and the table state. It needs no valid strobe and adds no latency.
- R2: Every predictor counter reads as taken when its most significant bit is 1. An update increments it on taken and decrements it on not-taken. It holds at all-ones and at zero instead of wrapping.
- R3: The global counter index is the low `GHIST_W` bits of the branch address XOR-ed with the `GHIST_W`-bit global history.
- R4: The local level-1 table is indexed by the low `LHT_IDX_W` address bits and holds an `LHIST_W`-bit history per entry. That history is used unchanged as the index of the local level-2 counter table.
- R5: The chooser entry is picked by the low `CHS_IDX_W` address bits. Its most significant bit at 1 selects the global prediction and at 0 selects the local one. On an update it increments when only the global component was right, decrements when only the local one was right, saturates at both ends, and otherwise holds.
- R6: Each update shifts the global history left by one, with the actual outcome entering bit 0. Without an update the history does not change.
- R7: Each update shifts the updated branch's local history entry left by one in the same way. Other entries are untouched.
- R8: When a prediction and an update happen in the same cycle, the prediction reflects the tables as they were before that update.
- R9: After reset every predictor counter is weakly not-taken (value 2^(CTR_W-1)-1), every chooser counter weakly favours global (value 2^(CHS_W-1)), and all histories are zero. Every address therefore predicts not-taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pred_pc_i | input | PC_W | Address of the branch to predict |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | Update strobe for a resolved branch |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |

## Verification
A lookup and a training write can land in the same cycle. When they do, the lookup must see only the old contents of the counters, the histories and the chooser, and never the values being written. The bench provokes this on every vector: it presents the same address on both ports in one cycle and samples the guess before the clock edge that commits the update. It compares that guess with a reference model from the requirements that trains only after the comparison. A directed case also updates an address whose counter is about to fall and checks that the guess is still the pre-update value.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic [1:0] {
    CTR_HOLD = 2'd0,
    CTR_INC  = 2'd1,
    CTR_DEC  = 2'd2
  } ctr_op_e;
endpackage

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned CTR_W   = 2,
  parameter int unsigned RST_VAL = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [CTR_W-1:0]    rd_ctr_o,
  input  logic [IDX_W-1:0]    up_idx_i,
  output logic [CTR_W-1:0]    up_ctr_o,
  input  tp_pkg::ctr_op_e     op_i
);
  localparam int unsigned     DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CMAX = '1;
  localparam logic [CTR_W-1:0] CRST = CTR_W'(RST_VAL);

  logic [CTR_W-1:0] mem_q [DEPTH];

  assign rd_ctr_o = mem_q[rd_idx_i];
  assign up_ctr_o = mem_q[up_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= CRST;
    end else begin
      unique case (op_i)
        tp_pkg::CTR_INC:
          if (mem_q[up_idx_i] != CMAX) mem_q[up_idx_i] <= mem_q[up_idx_i] + 1'b1;
        tp_pkg::CTR_DEC:
          if (mem_q[up_idx_i] != '0) mem_q[up_idx_i] <= mem_q[up_idx_i] - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int unsigned IDX_W  = 10,
  parameter int unsigned HIST_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   rd_idx_i,
  output logic [HIST_W-1:0]  rd_hist_o,
  input  logic [IDX_W-1:0]   up_idx_i,
  output logic [HIST_W-1:0]  up_hist_o,
  input  logic               we_i,
  input  logic               taken_i
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] hist_q [DEPTH];

  assign rd_hist_o = hist_q[rd_idx_i];
  assign up_hist_o = hist_q[up_idx_i];

  generate
    if (HIST_W > 1) begin : g_wide
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
        end else if (we_i) begin
          hist_q[up_idx_i] <= {hist_q[up_idx_i][HIST_W-2:0], taken_i};
        end
      end
    end else begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
        end else if (we_i) begin
          hist_q[up_idx_i] <= taken_i;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/tp_global_hist.sv
module tp_global_hist #(
  parameter int unsigned HIST_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              taken_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  generate
    if (HIST_W > 1) begin : g_wide
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   hist_q <= '0;
        else if (we_i) hist_q <= {hist_q[HIST_W-2:0], taken_i};
      end
    end else begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   hist_q <= '0;
        else if (we_i) hist_q <= taken_i;
      end
    end
  endgenerate

  assign hist_o = hist_q;
endmodule

// File: rtl/tourney_pred.sv
module tourney_pred #(
  parameter int unsigned PC_W      = 32,
  parameter int unsigned CTR_W     = 2,
  parameter int unsigned CHS_W     = 2,
  parameter int unsigned LHT_IDX_W = 10,
  parameter int unsigned LHIST_W   = 10,
  parameter int unsigned GHIST_W   = 12,
  parameter int unsigned CHS_IDX_W = 12
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam int unsigned CTR_RST = (1 << (CTR_W - 1)) - 1;
  localparam int unsigned CHS_RST = 1 << (CHS_W - 1);

  // whole address folded here so upper bits count as consumed
  logic pc_unused;
  assign pc_unused = ^{pred_pc_i, upd_pc_i};

  // global history
  logic [GHIST_W-1:0] ghist_q;
  tp_global_hist #(.HIST_W(GHIST_W)) u_ghist (
    .clk_i, .rst_ni,
    .we_i    (upd_valid_i),
    .taken_i (upd_taken_i),
    .hist_o  (ghist_q)
  );

  // local level 1
  logic [LHIST_W-1:0] lhist_p, lhist_u;
  tp_hist_table #(.IDX_W(LHT_IDX_W), .HIST_W(LHIST_W)) u_lht (
    .clk_i, .rst_ni,
    .rd_idx_i  (pred_pc_i[LHT_IDX_W-1:0]),
    .rd_hist_o (lhist_p),
    .up_idx_i  (upd_pc_i[LHT_IDX_W-1:0]),
    .up_hist_o (lhist_u),
    .we_i      (upd_valid_i),
    .taken_i   (upd_taken_i)
  );

  // direction op shared by both component tables
  tp_pkg::ctr_op_e dir_op;
  always_comb begin
    dir_op = tp_pkg::CTR_HOLD;
    if (upd_valid_i) dir_op = upd_taken_i ? tp_pkg::CTR_INC : tp_pkg::CTR_DEC;
  end

  // local level 2
  logic [CTR_W-1:0] lctr_p, lctr_u;
  tp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(CTR_W), .RST_VAL(CTR_RST)) u_lpt (
    .clk_i, .rst_ni,
    .rd_idx_i (lhist_p),
    .rd_ctr_o (lctr_p),
    .up_idx_i (lhist_u),
    .up_ctr_o (lctr_u),
    .op_i     (dir_op)
  );

  // global counters
  logic [GHIST_W-1:0] gidx_p, gidx_u;
  logic [CTR_W-1:0]   gctr_p, gctr_u;
  assign gidx_p = pred_pc_i[GHIST_W-1:0] ^ ghist_q;
  assign gidx_u = upd_pc_i[GHIST_W-1:0]  ^ ghist_q;

  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CTR_W), .RST_VAL(CTR_RST)) u_gpt (
    .clk_i, .rst_ni,
    .rd_idx_i (gidx_p),
    .rd_ctr_o (gctr_p),
    .up_idx_i (gidx_u),
    .up_ctr_o (gctr_u),
    .op_i     (dir_op)
  );

  // chooser
  logic            loc_ok, glb_ok;
  tp_pkg::ctr_op_e chs_op;
  logic [CHS_W-1:0] cctr_p, cctr_u;

  assign loc_ok = (lctr_u[CTR_W-1] == upd_taken_i);
  assign glb_ok = (gctr_u[CTR_W-1] == upd_taken_i);

  always_comb begin
    chs_op = tp_pkg::CTR_HOLD;
    if (upd_valid_i && (loc_ok != glb_ok))
      chs_op = glb_ok ? tp_pkg::CTR_INC : tp_pkg::CTR_DEC;
  end

  tp_ctr_table #(.IDX_W(CHS_IDX_W), .CTR_W(CHS_W), .RST_VAL(CHS_RST)) u_chs (
    .clk_i, .rst_ni,
    .rd_idx_i (pred_pc_i[CHS_IDX_W-1:0]),
    .rd_ctr_o (cctr_p),
    .up_idx_i (upd_pc_i[CHS_IDX_W-1:0]),
    .up_ctr_o (cctr_u),
    .op_i     (chs_op)
  );

  logic cctr_u_unused;
  assign cctr_u_unused = ^cctr_u;

  assign pred_taken_o = cctr_p[CHS_W-1] ? gctr_p[CTR_W-1] : lctr_p[CTR_W-1];
endmodule

// File: rtl/tp_checker.sv
module tp_checker #(
  parameter int unsigned GHIST_W = 12
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               upd_valid_i,
  input logic               upd_taken_i,
  input logic [GHIST_W-1:0] ghist_i,
  input logic               pred_taken_i,
  input logic               loc_ok_i,
  input logic               glb_ok_i,
  input tp_pkg::ctr_op_e    chs_op_i
);
  // R6
  p_ghist_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> ghist_i == GHIST_W'({$past(ghist_i), $past(upd_taken_i)}));

  // R6
  p_ghist_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(ghist_i));

  // R1
  p_pred_known_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(pred_taken_i));

  // R5
  p_chs_train_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chs_op_i != tp_pkg::CTR_HOLD) |-> (upd_valid_i && (loc_ok_i != glb_ok_i)));

  // R5
  p_chs_dir_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chs_op_i == tp_pkg::CTR_INC) |-> glb_ok_i);
endmodule

bind tourney_pred tp_checker #(.GHIST_W(GHIST_W)) u_tp_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .upd_valid_i  (upd_valid_i),
  .upd_taken_i  (upd_taken_i),
  .ghist_i      (ghist_q),
  .pred_taken_i (pred_taken_o),
  .loc_ok_i     (loc_ok),
  .glb_ok_i     (glb_ok),
  .chs_op_i     (chs_op)
);

// File: tb/tourney_pred_tb_top.sv
`timescale 1ns/1ps
module tourney_pred_tb_top;
  localparam int PC_W = 32;
  localparam int GN = 4096, LN = 1024, CN = 4096;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic [PC_W-1:0] pred_pc_i, upd_pc_i;
  logic pred_taken_o, upd_valid_i, upd_taken_i;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  tourney_pred dut_i (
    .clk_i, .rst_ni, .pred_pc_i, .pred_taken_o,
    .upd_valid_i, .upd_pc_i, .upd_taken_i
  );

  // reference model built from the requirements
  int bm_g [GN];
  int bm_l1[LN];
  int bm_l2[LN];
  int bm_c [CN];
  int bm_gh;

  task automatic bm_reset();
    for (int i = 0; i < GN; i++) bm_g[i] = 1;
    for (int i = 0; i < LN; i++) begin bm_l1[i] = 0; bm_l2[i] = 1; end
    for (int i = 0; i < CN; i++) bm_c[i] = 2;
    bm_gh = 0;
  endtask

  function automatic bit bm_pred(int pc);
    int gi = (pc & 12'hfff) ^ bm_gh;
    int lh = bm_l1[pc & 10'h3ff];
    if (bm_c[pc & 12'hfff] >= 2) return bm_g[gi] >= 2;
    return bm_l2[lh] >= 2;
  endfunction

  task automatic bm_update(int pc, bit t);
    int gi = (pc & 12'hfff) ^ bm_gh;
    int li = pc & 10'h3ff;
    int lh = bm_l1[li];
    int ci = pc & 12'hfff;
    bit lok = (bm_l2[lh] >= 2) == t;
    bit gok = (bm_g[gi] >= 2) == t;
    if (gok && !lok && bm_c[ci] < 3) bm_c[ci]++;
    if (lok && !gok && bm_c[ci] > 0) bm_c[ci]--;
    if (t) begin
      if (bm_g[gi] < 3) bm_g[gi]++;
      if (bm_l2[lh] < 3) bm_l2[lh]++;
    end else begin
      if (bm_g[gi] > 0) bm_g[gi]--;
      if (bm_l2[lh] > 0) bm_l2[lh]--;
    end
    bm_l1[li] = ((lh << 1) | int'(t)) & 10'h3ff;
    bm_gh = ((bm_gh << 1) | int'(t)) & 12'hfff;
  endtask

  task automatic check(string req, bit act, bit exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: pred_taken_o=%0b expected %0b", req, act, exp);
    end
  endtask

  // one cycle: predict pc, optional same-cycle update of upd_pc
  task automatic step(string req, int ppc, bit uv, int upc, bit t);
    @(negedge clk_i);
    pred_pc_i   = PC_W'(ppc);
    upd_valid_i = uv;
    upd_pc_i    = PC_W'(upc);
    upd_taken_i = t;
    #1;
    check(req, pred_taken_o, bm_pred(ppc));
    @(posedge clk_i);
    if (uv) bm_update(upc, t);
  endtask

  task automatic train(int pc, bit t);
    @(negedge clk_i);
    upd_valid_i = 1'b1; upd_pc_i = PC_W'(pc); upd_taken_i = t;
    @(posedge clk_i);
    bm_update(pc, t);
    @(negedge clk_i);
    upd_valid_i = 1'b0;
  endtask

  task automatic probe(string req, int pc, bit exp);
    @(negedge clk_i);
    upd_valid_i = 1'b0; pred_pc_i = PC_W'(pc);
    #1;
    check(req, pred_taken_o, exp);
  endtask

  // {pc[15:0], taken}: loop branch, alternating branch, correlated pair
  localparam logic [16:0] VEC [24] = '{
    {16'h0040, 1'b1}, {16'h0081, 1'b1}, {16'h0040, 1'b1}, {16'h0081, 1'b0},
    {16'h0040, 1'b1}, {16'h0081, 1'b1}, {16'h0040, 1'b0}, {16'h0081, 1'b0},
    {16'h0123, 1'b1}, {16'h0124, 1'b1}, {16'h0040, 1'b1}, {16'h0081, 1'b1},
    {16'h0123, 1'b0}, {16'h0124, 1'b0}, {16'h0040, 1'b1}, {16'h0081, 1'b0},
    {16'h0fff, 1'b1}, {16'h0040, 1'b1}, {16'h0081, 1'b1}, {16'h0040, 1'b0},
    {16'h0081, 1'b0}, {16'h0123, 1'b1}, {16'h0124, 1'b1}, {16'h0fff, 1'b0}
  };

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    pred_pc_i = '0; upd_pc_i = '0; upd_valid_i = 1'b0; upd_taken_i = 1'b0;
    bm_reset();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    // R9 / R1: reset state predicts not-taken everywhere
    probe("R9", 0, 1'b0);
    probe("R9", 5, 1'b0);
    probe("R1", 32'h0000_03ff, 1'b0);

    // R3: one taken at pc 5 -> ghist=1, so pc 4 now hits counter 5
    train(5, 1'b1);
    probe("R3", 4, 1'b1);
    probe("R3", 5, 1'b0);

    // R8: update pc 4 not-taken while predicting it: old value still seen
    step("R8", 4, 1'b1, 4, 1'b0);

    // R6: history holds without updates (prediction for pc 7 unchanged)
    probe("R6", 7, bm_pred(7));
    repeat (4) @(negedge clk_i);
    probe("R6", 7, bm_pred(7));

    // R4 / R5 / R7 / R8: table walk, predict and update same pc each cycle
    for (int pass = 0; pass < 5; pass++)
      for (int k = 0; k < 24; k++)
        step("R5", int'(VEC[k][16:1]), 1'b1, int'(VEC[k][16:1]), VEC[k][0]);

    // R2: saturation at the top, then a single decrement
    for (int k = 0; k < 16; k++) step("R2", 9, 1'b1, 9, 1'b1);
    step("R2", 9, 1'b1, 9, 1'b0);
    for (int k = 0; k < 4; k++) step("R2", 9, 1'b1, 9, 1'b1);
    // R2: saturation at the bottom
    for (int k = 0; k < 16; k++) step("R2", 9, 1'b1, 9, 1'b0);
    step("R2", 9, 1'b1, 9, 1'b1);

    // R7: local history of one branch, other entries untouched
    for (int k = 0; k < 12; k++) step("R7", 11, 1'b1, 11, k[0]);
    probe("R7", 12, bm_pred(12));

    // R9: reset again restores initial state
    @(negedge clk_i) rst_ni = 1'b0;
    bm_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    probe("R9", 9, 1'b0);
    probe("R9", 11, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule